// File: doc/BRIEF.md
# Instruction Fetch Request Master

This unit sits between an instruction cache and a 64-bit read bus. When the cache reports a line miss, the unit raises a bus fetch request carrying the line's word address. It holds that request until a slave accepts it, and it keeps at most two accepted requests in flight. When the slave accepts, the unit records whether that slave is 32 or 64 bits wide, and it keeps this width with the request.

Returned data beats belong to the oldest open request. For each beat, the unit picks the valid 32-bit lane or lanes using that request's recorded width. It then hands the cache one or two plain instruction words, each tagged with its word index inside the line. The cache can cancel a pending request. The cancel reaches the bus as an abort, and a request that is aborted in its accept cycle is never tracked.

Top module: `ifetch_master`

## Requirements
- R1: Once raised, `bus_req` stays high, and `bus_addr` stays constant, until a cycle in which `bus_addr_ack` is high.
- R2: In the cycle after an accept, `bus_req` is low. If a new miss is waiting, `bus_req` rises again two cycles after the accept cycle.
- R3: While two accepted requests are open, `miss_ready` is low and no new request is raised.
- R4: This rule applies when the final data beat of the oldest request arrives while two requests are open. In the next cycle `bus_req` is still low, and a waiting miss raises `bus_req` in the cycle after that.
- R5: `bus_wide` is sampled only in the accept cycle, and its value governs every beat of that request. Beats are matched to requests in issue order.
- R6: Narrow request (width 0). One cycle after each data beat, `out_vld`=01 and `out_idx0`=`bus_rd_word`. `out_data0` is `bus_rd_data[63:32]` when `bus_rd_word[0]`=0, and `bus_rd_data[31:0]` when it is 1.
- R7: Wide request (width 1). One cycle after each beat, `out_vld`=11. `out_data0`=`bus_rd_data[63:32]` with index {`bus_rd_word[2:1]`,0}, and `out_data1`=`bus_rd_data[31:0]` with index {`bus_rd_word[2:1]`,1}. Bit 0 of `bus_rd_word` is ignored.
- R8: `bus_abort` equals `bus_req` AND `miss_cancel`. A request accepted while aborted takes no tracking slot.
- R9: A request closes after 8 beats if narrow, or 4 beats if wide (for a line of 8 words).
- R10: A data beat that arrives while no request is open produces no output (`out_vld`=00 in the next cycle).
- R11: During and right after reset, `bus_req`=0, `out_vld`=00 and `miss_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid | input | 1 | Cache has a line miss to fetch |
| miss_addr | input | 30 | Word address of the missed line |
| miss_cancel | input | 1 | Cache withdraws the pending request |
| miss_ready | output | 1 | Miss is taken this cycle |
| bus_req | output | 1 | Fetch request to the bus |
| bus_addr | output | 30 | Word address of the fetch |
| bus_abort | output | 1 | Abort of the pending fetch |
| bus_addr_ack | input | 1 | Slave accepts the request |
| bus_wide | input | 1 | Slave width in accept cycle: 1 = 64 bit |
| bus_rd_ack | input | 1 | Data beat valid |
| bus_rd_data | input | 64 | Beat data, bits 63:32 upper lane |
| bus_rd_word | input | 3 | Word index of the beat |
| out_vld | output | 2 | Bit 0: word 0 valid, bit 1: word 1 valid |
| out_data0 | output | 32 | First delivered word |
| out_data1 | output | 32 | Second delivered word (wide beats) |
| out_idx0 | output | 3 | Line index of word 0 |
| out_idx1 | output | 3 | Line index of word 1 |

## Verification
A wrong open-request count shows at the ports in one of two ways. If it is too high, `miss_ready` stays low after an aborted accept or after a final beat, within one cycle. If it is too low, a stray beat after the last line produces words. A width bit stored in the wrong slot, or a beat counter that is off by one, makes the second request's beats come out in the wrong lane mode. That error appears on the very next beat after the first request's boundary. A late or early retire moves the third request's rising edge by a cycle, and the bench checks that edge in the exact cycle it should occur.

// File: rtl/ifm_pkg.sv
// Shared widths and types for the instruction fetch master.
// Assumes a 64-bit read bus made of two 32-bit lanes.
package ifm_pkg;
    localparam int LANE_W = 32;
    localparam int BUS_W  = 2 * LANE_W;
    localparam int MAX_OPEN = 2;

    typedef logic [LANE_W-1:0] word_t;
    typedef logic [BUS_W-1:0]  beat_t;
endpackage

// File: rtl/ifm_issue.sv
// Request issue stage. Latches a cache miss into a bus request and holds it
// until the slave accepts. Because the request register drops after an
// accept, there is always at least one idle cycle between requests.
// Assumes slot_free already reflects accepts and retires from earlier cycles.
module ifm_issue #(
    parameter int AW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    input  logic          miss_cancel,
    input  logic          slot_free,
    input  logic          addr_ack,
    output logic          miss_ready,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_abort,
    output logic          alloc
);
    logic          req_q;
    logic [AW-1:0] addr_q;

    // Take a miss only while idle and a tracking slot is available
    always_comb miss_ready = !req_q && slot_free;

    // Request register: set on a taken miss, cleared on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else if (req_q && addr_ack) begin
            req_q  <= 1'b0;
        end else if (miss_valid && miss_ready) begin
            req_q  <= 1'b1;
            addr_q <= miss_addr;
        end
    end

    // Bus-facing outputs and slot allocation on a non-aborted accept
    always_comb begin
        bus_req   = req_q;
        bus_addr  = addr_q;
        bus_abort = req_q && miss_cancel;
        alloc     = req_q && addr_ack && !miss_cancel;
    end

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !addr_ack) |=> (bus_req && $stable(bus_addr)));
    // R2
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && addr_ack) |=> !bus_req);
endmodule

// File: rtl/ifm_track.sv
// Open-request tracker. Holds up to two accepted requests in issue order,
// each with the slave width seen at accept time. It counts data beats
// against the oldest request and retires that request on its last beat.
// Assumes the slave returns requests strictly in order.
module ifm_track #(
    parameter int LINE_WORDS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alloc,
    input  logic alloc_wide,
    input  logic rd_ack,
    output logic head_vld,
    output logic head_wide,
    output logic slot_free,
    output logic retire
);
    localparam int DEPTH        = ifm_pkg::MAX_OPEN;
    localparam int NARROW_BEATS = LINE_WORDS;
    localparam int WIDE_BEATS   = LINE_WORDS / 2;
    localparam int BCW          = $clog2(NARROW_BEATS);
    localparam int CW           = $clog2(DEPTH + 1);
    localparam int PW           = $clog2(DEPTH);

    logic [DEPTH-1:0] wide_q;
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt;
    logic [BCW-1:0]   beat_q;
    logic             take, last_beat;

    // Width bit per slot, written on allocation
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                wide_q[i] <= 1'b0;
            else if (alloc && wr_ptr == PW'(i))
                wide_q[i] <= alloc_wide;
        end
    end

    // Head status, beat acceptance and the last-beat decision
    always_comb begin
        head_vld  = cnt != '0;
        head_wide = wide_q[rd_ptr];
        slot_free = cnt < CW'(DEPTH);
        take      = rd_ack && head_vld;
        last_beat = head_wide ? (beat_q == BCW'(WIDE_BEATS - 1))
                              : (beat_q == BCW'(NARROW_BEATS - 1));
        retire    = take && last_beat;
    end

    // Pointers, occupancy and the beat counter of the head request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            beat_q <= '0;
        end else begin
            if (alloc)  wr_ptr <= wr_ptr + 1'b1;
            if (retire) rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(alloc) - CW'(retire);
            if (retire)    beat_q <= '0;
            else if (take) beat_q <= beat_q + 1'b1;
        end
    end

    // R3
    open_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R3
    no_alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc && !slot_free && !retire));
    // R9
    beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_vld && head_wide) |-> (beat_q < BCW'(WIDE_BEATS)));
endmodule

// File: rtl/ifm_lane.sv
// Lane steering. Turns one bus beat into one or two cache words with line
// indices. The output is registered, so words appear one cycle after the beat.
// Assumes the upper lane (bits 63:32) carries the even word.
module ifm_lane #(
    parameter int IW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 wide,
    input  ifm_pkg::beat_t       rd_data,
    input  logic [IW-1:0]        rd_word,
    output logic [1:0]           out_vld,
    output ifm_pkg::word_t       out_data0,
    output ifm_pkg::word_t       out_data1,
    output logic [IW-1:0]        out_idx0,
    output logic [IW-1:0]        out_idx1
);
    localparam int LW = ifm_pkg::LANE_W;

    ifm_pkg::word_t up_w, lo_w;

    // Split the beat into its two lanes
    always_comb begin
        up_w = rd_data[2*LW-1:LW];
        lo_w = rd_data[LW-1:0];
    end

    // Register the selected words and their indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 2'b00;
            out_data0 <= '0;
            out_data1 <= '0;
            out_idx0  <= '0;
            out_idx1  <= '0;
        end else begin
            out_vld   <= take ? {wide, 1'b1} : 2'b00;
            out_data0 <= (!wide && rd_word[0]) ? lo_w : up_w;
            out_data1 <= lo_w;
            out_idx0  <= wide ? {rd_word[IW-1:1], 1'b0} : rd_word;
            out_idx1  <= {rd_word[IW-1:1], 1'b1};
        end
    end

    // R7
    lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld != 2'b10);
    // R6
    narrow_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wide) |=> (out_idx0 == $past(rd_word)));
endmodule

// File: rtl/ifetch_master.sv
// Instruction fetch request master: issue, in-order tracking of up to two
// open requests, and per-request lane steering of returned beats.
// Assumes LINE_WORDS is a power of two, at least 4, with 3-bit word indices
// at the default size.
module ifetch_master #(
    parameter int AW         = 30,
    parameter int LINE_WORDS = 8,
    localparam int IW        = $clog2(LINE_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    input  logic          miss_cancel,
    output logic          miss_ready,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_abort,
    input  logic          bus_addr_ack,
    input  logic          bus_wide,
    input  logic          bus_rd_ack,
    input  logic [63:0]   bus_rd_data,
    input  logic [IW-1:0] bus_rd_word,
    output logic [1:0]    out_vld,
    output logic [31:0]   out_data0,
    output logic [31:0]   out_data1,
    output logic [IW-1:0] out_idx0,
    output logic [IW-1:0] out_idx1
);
    logic alloc, slot_free, head_vld, head_wide, retire;

    ifm_issue #(.AW(AW)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_cancel(miss_cancel), .slot_free(slot_free),
        .addr_ack(bus_addr_ack), .miss_ready(miss_ready),
        .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_abort(bus_abort), .alloc(alloc)
    );

    ifm_track #(.LINE_WORDS(LINE_WORDS)) u_track (
        .clk(clk), .rst_n(rst_n),
        .alloc(alloc), .alloc_wide(bus_wide), .rd_ack(bus_rd_ack),
        .head_vld(head_vld), .head_wide(head_wide),
        .slot_free(slot_free), .retire(retire)
    );

    ifm_lane #(.IW(IW)) u_lane (
        .clk(clk), .rst_n(rst_n),
        .take(bus_rd_ack && head_vld), .wide(head_wide),
        .rd_data(bus_rd_data), .rd_word(bus_rd_word),
        .out_vld(out_vld), .out_data0(out_data0), .out_data1(out_data1),
        .out_idx0(out_idx0), .out_idx1(out_idx1)
    );

    // R4
    third_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_free && retire) |=> !bus_req);
    // R10
    stray_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_ack && !head_vld) |=> (out_vld == 2'b00));
endmodule

// File: tb/ifetch_master_tb.sv
`timescale 1ns/1ps
module ifetch_master_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid, miss_cancel, bus_addr_ack, bus_wide, bus_rd_ack;
    logic [29:0] miss_addr;
    logic [63:0] bus_rd_data;
    logic [2:0]  bus_rd_word;
    logic        miss_ready, bus_req, bus_abort;
    logic [29:0] bus_addr;
    logic [1:0]  out_vld;
    logic [31:0] out_data0, out_data1;
    logic [2:0]  out_idx0, out_idx1;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    ifetch_master u_dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_cancel(miss_cancel), .miss_ready(miss_ready), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_abort(bus_abort), .bus_addr_ack(bus_addr_ack),
        .bus_wide(bus_wide), .bus_rd_ack(bus_rd_ack), .bus_rd_data(bus_rd_data),
        .bus_rd_word(bus_rd_word), .out_vld(out_vld), .out_data0(out_data0),
        .out_data1(out_data1), .out_idx0(out_idx0), .out_idx1(out_idx1)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] up_of(int tag, int k);
        return 32'hA000_0000 + (tag << 8) + k;
    endfunction
    function automatic logic [31:0] lo_of(int tag, int k);
        return 32'h5000_0000 + (tag << 8) + k;
    endfunction

    // Return one full line for the oldest request and check every delivered word
    task automatic deliver(int tag, bit wide, int s);
        int nb = wide ? 4 : 8;
        for (int k = 0; k < nb; k++) begin
            int w;
            int pair;
            pair = ((s / 2) + k) % 4;
            w = wide ? (pair * 2 + (k & 1)) : ((s + k) % 8);
            bus_rd_ack  = 1'b1;
            bus_rd_word = 3'(w);
            bus_rd_data = {up_of(tag, k), lo_of(tag, k)};
            step();
            if (wide) begin
                // R7 both lanes, even/odd indices, bit 0 of word ignored
                chk("R7 vld",  64'(out_vld),   64'(2'b11));
                chk("R7 d0",   64'(out_data0), 64'(up_of(tag, k)));
                chk("R7 d1",   64'(out_data1), 64'(lo_of(tag, k)));
                chk("R7 i0",   64'(out_idx0),  64'(pair * 2));
                chk("R7 i1",   64'(out_idx1),  64'(pair * 2 + 1));
            end else begin
                // R6 lane picked by word bit 0
                chk("R6 vld",  64'(out_vld),   64'(2'b01));
                chk("R6 d0",   64'(out_data0), 64'((w % 2) ? lo_of(tag, k) : up_of(tag, k)));
                chk("R6 i0",   64'(out_idx0),  64'(w));
            end
        end
        bus_rd_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int tag = 0;
        rst_n = 1'b0; miss_valid = 0; miss_cancel = 0; miss_addr = '0;
        bus_addr_ack = 0; bus_wide = 0; bus_rd_ack = 0; bus_rd_data = '0; bus_rd_word = '0;
        step(); step();
        // R11 reset state
        chk("R11 req",   64'(bus_req),    64'(0));
        chk("R11 vld",   64'(out_vld),    64'(0));
        chk("R11 ready", 64'(miss_ready), 64'(1));
        rst_n = 1'b1;
        step();
        chk("R11 ready after", 64'(miss_ready), 64'(1));

        for (int wa = 0; wa < 2; wa++)
        for (int wb = 0; wb < 2; wb++)
        for (int s = 0; s < 8; s++) begin
            logic [29:0] a_addr, b_addr, c_addr;
            tag++;
            a_addr = 30'(tag * 24);
            b_addr = a_addr + 30'd8;
            c_addr = a_addr + 30'd16;
            // Request A, accepted after two waiting cycles
            miss_valid = 1; miss_addr = a_addr;
            step();
            miss_valid = 0; miss_addr = '1;
            chk("R1 req", 64'(bus_req), 64'(1));
            chk("R1 addr", 64'(bus_addr), 64'(a_addr));
            step();
            chk("R1 hold", 64'(bus_req), 64'(1));
            chk("R1 addr hold", 64'(bus_addr), 64'(a_addr));
            bus_addr_ack = 1; bus_wide = 1'(wa);
            step();
            bus_addr_ack = 0; bus_wide = ~1'(wa);   // R5: width outside accept is ignored
            chk("R2 gap", 64'(bus_req), 64'(0));
            // Request B
            miss_valid = 1; miss_addr = b_addr;
            step();
            miss_valid = 0;
            chk("R2 rerise", 64'(bus_req), 64'(1));
            chk("R2 addr", 64'(bus_addr), 64'(b_addr));
            bus_addr_ack = 1; bus_wide = 1'(wb);
            step();
            bus_addr_ack = 0; bus_wide = ~1'(wb);
            // Third miss waits while two are open
            miss_valid = 1; miss_addr = c_addr;
            #1;
            chk("R3 ready", 64'(miss_ready), 64'(0));
            step();
            chk("R3 no req", 64'(bus_req), 64'(0));
            // A's beats, interpreted with A's width (R5, R9)
            deliver(tag, 1'(wa), s);
            chk("R4 still low", 64'(bus_req), 64'(0));
            step();
            miss_valid = 0;
            chk("R4 rise", 64'(bus_req), 64'(1));
            chk("R4 addr", 64'(bus_addr), 64'(c_addr));
            // Abort C in its accept cycle
            miss_cancel = 1; bus_addr_ack = 1;
            #1;
            chk("R8 abort", 64'(bus_abort), 64'(1));
            step();
            miss_cancel = 0; bus_addr_ack = 0;
            chk("R8 req drop", 64'(bus_req), 64'(0));
            chk("R8 no slot", 64'(miss_ready), 64'(1));
            // B's beats with B's width, in order after A (R5, R9)
            deliver(tag + 64, 1'(wb), 7 - s);
            // Nothing open now: a stray beat gives nothing (R10, R8, R9)
            bus_rd_ack = 1; bus_rd_word = 3'(s);
            step();
            bus_rd_ack = 0;
            chk("R10 stray", 64'(out_vld), 64'(0));
            step();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule